// File: doc/BRIEF.md
# Acquire-Release Access Issue Gate

This block sits between a core and a memory port that accepts several accesses before any of them finishes. Each operation the core presents carries an ordering class: plain data, acquire, release or full sync. The gate hands every accepted operation a free transaction ID, tracks which IDs are still in flight, and decides cycle by cycle whether the pending operation may go out. The decision follows either release-consistency rules or weak-ordering rules, picked by a mode pin. Memory returns completions in any order, each naming the ID it retires.

Under release consistency an acquire may overtake older data accesses but fences everything behind it until it completes. A release waits for everything older to drain but does not hold back anything younger. A sync both drains and fences. Under weak ordering every non-data operation is treated as a sync. Data accesses between ordering points are never ordered against each other. A count of accesses in flight and a blocked flag are exported for observation.

Top module: `acqrel_issue_gate`

## Requirements
- R1: After reset the in-flight count is 0, the blocked flag is low and a data request is accepted at once.
- R2: Accepted operations receive the lowest-numbered transaction ID not currently in flight, and an ID is never handed out twice while in flight.
- R3: With all 8 IDs in flight, no operation is accepted and the blocked flag is high while a request is presented.
- R4: The in-flight count rises by one for each accepted operation and falls by one for each completion; an acceptance and a completion in the same cycle leave it unchanged.
- R5: In release-consistency mode (mode pin 0), an acquire (class code 1) is accepted while older data accesses (class code 0) are in flight.
- R6: In release-consistency mode, once an acquire is accepted no further operation is accepted until the completion carrying the acquire's ID has been received; acceptance resumes the cycle after that completion.
- R7: In release-consistency mode, a release (class code 2) is not accepted until the in-flight count is 0.
- R8: In release-consistency mode, operations after an accepted release are accepted while the release is still in flight.
- R9: In weak-ordering mode (mode pin 1), a sync (class code 3), an acquire or a release is not accepted until the in-flight count is 0.
- R10: In weak-ordering mode, after a sync, acquire or release is accepted no further operation is accepted until its completion has been received.
- R11: Completions may arrive in any order; each frees exactly the ID it carries, and a freed ID becomes available again the next cycle.
- R12: The blocked flag is high exactly when a request is presented and an ordering or capacity rule holds it; memory back-pressure alone drops ready but leaves the blocked flag low.
- R13: In release-consistency mode a sync both waits for the count to reach 0 and fences younger operations until its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_mode_i | input | 1 | 0 = release consistency, 1 = weak ordering |
| op_valid_i | input | 1 | Core presents an operation |
| op_kind_i | input | 2 | Ordering class: 0 data, 1 acquire, 2 release, 3 sync |
| op_ready_o | output | 1 | Operation accepted this cycle when valid is also high |
| mem_valid_o | output | 1 | Operation offered to memory port |
| mem_id_o | output | 3 | Transaction ID attached to the offered operation |
| mem_ready_i | input | 1 | Memory port can take an operation |
| cpl_valid_i | input | 1 | A completion is returned this cycle |
| cpl_id_i | input | 3 | Transaction ID of the returned completion |
| out_count_o | output | 4 | Number of transactions in flight |
| gate_blocked_o | output | 1 | Pending operation held by an ordering or capacity rule |

## Verification
On every cycle the assertions check that an active fence keeps ready low, that a draining class is refused while anything is in flight, that a full table refuses all, that the count steps by acceptances minus completions, and that a handed-out ID is never already in flight. What only the scenarios show is the exact cycle where acceptance resumes after the fencing operation's completion, lowest-free ID reuse after out-of-order completions, and that releases let younger data through in release-consistency mode but not in weak-ordering mode.

// File: rtl/aqr_pkg.sv
package aqr_pkg;

  typedef enum logic [1:0] {
    OP_DATA = 2'd0,
    OP_ACQ  = 2'd1,
    OP_REL  = 2'd2,
    OP_SYNC = 2'd3
  } op_kind_e;

  typedef enum logic {
    ORD_RC = 1'b0,
    ORD_WO = 1'b1
  } ord_mode_e;

  // Operation must wait for every older access to finish before leaving.
  function automatic logic must_drain(ord_mode_e m, op_kind_e k);
    if (m == ORD_WO) return k != OP_DATA;
    return (k == OP_REL) || (k == OP_SYNC);
  endfunction

  // Operation holds every younger access until its own completion.
  function automatic logic sets_fence(ord_mode_e m, op_kind_e k);
    if (m == ORD_WO) return k != OP_DATA;
    return (k == OP_ACQ) || (k == OP_SYNC);
  endfunction

endpackage

// File: rtl/aqr_slot_table.sv
module aqr_slot_table #(
  parameter int ID_W  = 3,
  localparam int SLOTS = 1 << ID_W,
  localparam int CNT_W = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [ID_W-1:0]  set_id,
  input  logic             clr_en,
  input  logic [ID_W-1:0]  clr_id,
  output logic [SLOTS-1:0] busy,
  output logic             free_any,
  output logic [ID_W-1:0]  free_id,
  output logic [CNT_W-1:0] count
);

  function automatic logic [ID_W-1:0] lowest_clear(logic [SLOTS-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!v[i]) r = ID_W'(i);
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] ones(logic [SLOTS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < SLOTS; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [SLOTS-1:0] set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_en) set_mask[set_id] = 1'b1;
    if (clr_en) clr_mask[clr_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~clr_mask) | set_mask;
  end

  assign free_any = ~&busy;
  assign free_id  = lowest_clear(busy);
  assign count    = ones(busy);

endmodule

// File: rtl/aqr_fence_reg.sv
module aqr_fence_reg #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [ID_W-1:0] arm_id,
  input  logic            cpl_valid,
  input  logic [ID_W-1:0] cpl_id,
  output logic            fence_on,
  output logic [ID_W-1:0] fence_id
);

  logic release_hit;
  assign release_hit = fence_on && cpl_valid && (cpl_id == fence_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fence_on <= 1'b0;
      fence_id <= '0;
    end else if (arm) begin
      fence_on <= 1'b1;
      fence_id <= arm_id;
    end else if (release_hit) begin
      fence_on <= 1'b0;
    end
  end

endmodule

// File: rtl/aqr_order_rules.sv
module aqr_order_rules
  import aqr_pkg::*;
#(
  parameter int ID_W  = 3,
  localparam int CNT_W = ID_W + 1
) (
  input  ord_mode_e        mode,
  input  op_kind_e         kind,
  input  logic             fence_on,
  input  logic             free_any,
  input  logic [CNT_W-1:0] count,
  output logic             hold_fence,
  output logic             hold_drain,
  output logic             hold_full,
  output logic             gate_ok,
  output logic             arms_fence
);

  assign hold_fence = fence_on;
  assign hold_drain = must_drain(mode, kind) && (count != '0);
  assign hold_full  = !free_any;
  assign gate_ok    = !(hold_fence || hold_drain || hold_full);
  assign arms_fence = sets_fence(mode, kind);

endmodule

// File: rtl/acqrel_issue_gate.sv
module acqrel_issue_gate
  import aqr_pkg::*;
#(
  parameter int ID_W  = 3,
  localparam int SLOTS = 1 << ID_W,
  localparam int CNT_W = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ord_mode_i,
  input  logic             op_valid_i,
  input  logic [1:0]       op_kind_i,
  output logic             op_ready_o,
  output logic             mem_valid_o,
  output logic [ID_W-1:0]  mem_id_o,
  input  logic             mem_ready_i,
  input  logic             cpl_valid_i,
  input  logic [ID_W-1:0]  cpl_id_i,
  output logic [CNT_W-1:0] out_count_o,
  output logic             gate_blocked_o
);

  ord_mode_e        mode;
  op_kind_e         kind;
  logic [SLOTS-1:0] busy;
  logic             free_any;
  logic [ID_W-1:0]  free_id;
  logic [CNT_W-1:0] count;
  logic             fence_on;
  logic [ID_W-1:0]  fence_id;
  logic             hold_fence, hold_drain, hold_full;
  logic             gate_ok, arms_fence;
  logic             issue_fire;

  assign mode = ord_mode_e'(ord_mode_i);
  assign kind = op_kind_e'(op_kind_i);

  aqr_slot_table #(.ID_W(ID_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (issue_fire),
    .set_id   (free_id),
    .clr_en   (cpl_valid_i),
    .clr_id   (cpl_id_i),
    .busy     (busy),
    .free_any (free_any),
    .free_id  (free_id),
    .count    (count)
  );

  aqr_order_rules #(.ID_W(ID_W)) u_rules (
    .mode       (mode),
    .kind       (kind),
    .fence_on   (fence_on),
    .free_any   (free_any),
    .count      (count),
    .hold_fence (hold_fence),
    .hold_drain (hold_drain),
    .hold_full  (hold_full),
    .gate_ok    (gate_ok),
    .arms_fence (arms_fence)
  );

  aqr_fence_reg #(.ID_W(ID_W)) u_fence (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (issue_fire && arms_fence),
    .arm_id    (free_id),
    .cpl_valid (cpl_valid_i),
    .cpl_id    (cpl_id_i),
    .fence_on  (fence_on),
    .fence_id  (fence_id)
  );

  assign op_ready_o     = gate_ok && mem_ready_i;
  assign mem_valid_o    = op_valid_i && gate_ok;
  assign mem_id_o       = free_id;
  assign issue_fire     = op_valid_i && op_ready_o;
  assign out_count_o    = count;
  assign gate_blocked_o = op_valid_i && !gate_ok;

endmodule

// File: rtl/aqr_gate_chk.sv
module aqr_gate_chk
  import aqr_pkg::*;
#(
  parameter int ID_W  = 3,
  localparam int SLOTS = 1 << ID_W,
  localparam int CNT_W = ID_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ord_mode_i,
  input logic             op_valid_i,
  input logic [1:0]       op_kind_i,
  input logic             op_ready_o,
  input logic [ID_W-1:0]  mem_id_o,
  input logic             cpl_valid_i,
  input logic [CNT_W-1:0] out_count_o,
  input logic             gate_blocked_o,
  input logic [SLOTS-1:0] busy,
  input logic             fence_on
);

  logic fire;
  assign fire = op_valid_i && op_ready_o;

  // R6 R10 R13: a live fence keeps the core waiting
  a_r6_fence_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fence_on |-> !op_ready_o);

  // R7 R9: draining classes wait for an empty table
  a_r7_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && out_count_o != '0 &&
     must_drain(ord_mode_e'(ord_mode_i), op_kind_e'(op_kind_i))) |-> !op_ready_o);

  // R3: full table refuses everything
  a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (out_count_o == CNT_W'(SLOTS)) |-> !op_ready_o);

  // R4: count follows acceptances minus completions
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((CNT_W+1)'(out_count_o) ==
              (CNT_W+1)'($past(out_count_o)) + (CNT_W+1)'($past(fire))
              - (CNT_W+1)'($past(cpl_valid_i))));

  // R2: issued ID is not already in flight
  a_r2_fresh_id: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy[mem_id_o]);

  // R10: weak-ordering point arms the fence after acceptance
  a_r10_wo_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ord_mode_i && op_kind_i != 2'd0) |=> fence_on);

  // R12: a blocked request is never accepted
  a_r12_blocked_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    gate_blocked_o |-> !op_ready_o);

endmodule

bind acqrel_issue_gate aqr_gate_chk #(.ID_W(ID_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ord_mode_i     (ord_mode_i),
  .op_valid_i     (op_valid_i),
  .op_kind_i      (op_kind_i),
  .op_ready_o     (op_ready_o),
  .mem_id_o       (mem_id_o),
  .cpl_valid_i    (cpl_valid_i),
  .out_count_o    (out_count_o),
  .gate_blocked_o (gate_blocked_o),
  .busy           (busy),
  .fence_on       (fence_on)
);

// File: tb/sim_acqrel_issue_gate.sv
module sim_acqrel_issue_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ord_mode_i, op_valid_i, mem_ready_i, cpl_valid_i;
  logic [1:0] op_kind_i;
  logic [2:0] cpl_id_i, mem_id_o;
  logic       op_ready_o, mem_valid_o, gate_blocked_o;
  logic [3:0] out_count_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  acqrel_issue_gate u0 (
    .clk(clk), .rst_n(rst_n), .ord_mode_i(ord_mode_i), .op_valid_i(op_valid_i),
    .op_kind_i(op_kind_i), .op_ready_o(op_ready_o), .mem_valid_o(mem_valid_o),
    .mem_id_o(mem_id_o), .mem_ready_i(mem_ready_i), .cpl_valid_i(cpl_valid_i),
    .cpl_id_i(cpl_id_i), .out_count_o(out_count_o), .gate_blocked_o(gate_blocked_o)
  );

  // row: {req, mode, valid, kind, cpl_v, cpl_id, exp_ready, exp_id, exp_count}
  function automatic logic [19:0] mk(int rq, int md, int rv, int kd, int cv, int ci,
                                     int er, int ei, int ec);
    return {4'(rq), 1'(md), 1'(rv), 2'(kd), 1'(cv), 3'(ci), 1'(er), 3'(ei), 4'(ec)};
  endfunction

  localparam int NROW = 35;
  localparam logic [19:0] TBL [NROW] = '{
    mk(2, 0,1,0, 0,0, 1,0,1),   // R2 data
    mk(2, 0,1,0, 0,0, 1,1,2),
    mk(5, 0,1,1, 0,0, 1,2,3),   // R5 acquire over data
    mk(6, 0,1,0, 0,0, 0,0,3),   // R6 fenced
    mk(6, 0,1,0, 1,0, 0,0,2),
    mk(6, 0,1,0, 1,2, 0,0,1),   // R6 acquire completes, still held this cycle
    mk(11,0,1,0, 0,0, 1,0,2),   // R11 id 0 reused
    mk(7, 0,1,2, 0,0, 0,0,2),   // R7 release waits
    mk(7, 0,1,2, 1,1, 0,0,1),
    mk(7, 0,1,2, 1,0, 0,0,0),
    mk(7, 0,1,2, 0,0, 1,0,1),
    mk(8, 0,1,0, 0,0, 1,1,2),   // R8 younger passes release
    mk(4, 0,0,0, 1,0, 1,0,1),
    mk(4, 0,0,0, 1,1, 1,0,0),
    mk(2, 1,1,0, 0,0, 1,0,1),
    mk(2, 1,1,0, 0,0, 1,1,2),
    mk(9, 1,1,3, 0,0, 0,0,2),   // R9 sync drains
    mk(9, 1,1,3, 1,1, 0,0,1),
    mk(9, 1,1,3, 1,0, 0,0,0),
    mk(9, 1,1,3, 0,0, 1,0,1),
    mk(10,1,1,0, 0,0, 0,0,1),   // R10 held behind sync
    mk(10,1,1,0, 1,0, 0,0,0),
    mk(10,1,1,0, 0,0, 1,0,1),
    mk(9, 1,1,2, 0,0, 0,0,1),   // R9 release drains in WO
    mk(9, 1,1,2, 1,0, 0,0,0),
    mk(9, 1,1,2, 0,0, 1,0,1),
    mk(10,1,1,0, 1,0, 0,0,0),   // R10 release fences in WO
    mk(9, 1,1,1, 0,0, 1,0,1),
    mk(10,1,0,0, 1,0, 0,0,0),
    mk(2, 0,1,0, 0,0, 1,0,1),
    mk(13,0,1,3, 0,0, 0,0,1),   // R13 sync drains in RC
    mk(13,0,1,3, 1,0, 0,0,0),
    mk(13,0,1,3, 0,0, 1,0,1),
    mk(13,0,1,0, 0,0, 0,0,1),   // R13 sync fences in RC
    mk(13,0,0,0, 1,0, 0,0,0)
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit md, input bit rv, input int kd, input bit cv, input int ci);
    @(negedge clk);
    ord_mode_i = md; op_valid_i = rv; op_kind_i = 2'(kd);
    cpl_valid_i = cv; cpl_id_i = 3'(ci);
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ord_mode_i = 0; op_valid_i = 0; op_kind_i = 0;
    mem_ready_i = 1; cpl_valid_i = 0; cpl_id_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    drive(0, 1, 0, 0, 0);
    chk(out_count_o == 0, "R1 count", out_count_o, 0);
    chk(!gate_blocked_o, "R1 blocked", gate_blocked_o, 0);
    chk(op_ready_o, "R1 ready", op_ready_o, 1);
    @(negedge clk); op_valid_i = 0;
    @(posedge clk); #1;
    chk(out_count_o == 1, "R1 first accept", out_count_o, 1);
    drive(0, 0, 0, 1, 0);
    after_edge();

    for (int i = 0; i < NROW; i++) begin
      logic [19:0] r;
      string tg;
      r = TBL[i];
      tg = $sformatf("R%0d row%0d", r[19:16], i);
      drive(r[15], r[14], r[13:12], r[11], r[10:8]);
      chk(op_ready_o == r[7], {tg, " ready"}, op_ready_o, r[7]);
      chk(gate_blocked_o == (r[14] && !r[7]), {tg, " R12 blocked"},
          gate_blocked_o, r[14] && !r[7]);
      if (r[14] && r[7]) chk(mem_id_o == r[6:4], {tg, " id"}, mem_id_o, r[6:4]);
      after_edge();
      chk(out_count_o == r[3:0], {tg, " count"}, out_count_o, r[3:0]);
    end

    // R2 R3: fill all eight IDs
    for (int k = 0; k < 8; k++) begin
      drive(0, 1, 0, 0, 0);
      chk(op_ready_o && mem_id_o == 3'(k), "R2 fill id", mem_id_o, k);
      after_edge();
    end
    chk(out_count_o == 8, "R3 count full", out_count_o, 8);
    drive(0, 1, 0, 1, 5);
    chk(!op_ready_o, "R3 full ready", op_ready_o, 0);
    chk(gate_blocked_o, "R3 full blocked", gate_blocked_o, 1);
    after_edge();
    drive(0, 0, 0, 1, 2);
    after_edge();
    chk(out_count_o == 6, "R11 out of order", out_count_o, 6);
    drive(0, 1, 0, 0, 0);
    chk(op_ready_o && mem_id_o == 2, "R11 lowest free", mem_id_o, 2);
    after_edge();
    drive(0, 1, 0, 1, 7);
    chk(op_ready_o && mem_id_o == 5, "R11 next free", mem_id_o, 5);
    after_edge();
    chk(out_count_o == 7, "R4 same cycle", out_count_o, 7);

    // R12 back-pressure only
    mem_ready_i = 0;
    drive(0, 1, 0, 0, 0);
    chk(!op_ready_o, "R12 bp ready", op_ready_o, 0);
    chk(!gate_blocked_o, "R12 bp blocked", gate_blocked_o, 0);
    chk(mem_valid_o, "R12 bp offer", mem_valid_o, 1);
    after_edge();
    mem_ready_i = 1;
    chk(out_count_o == 7, "R12 bp count", out_count_o, 7);

    for (int k = 0; k < 7; k++) begin
      drive(0, 0, 0, 1, k);
      after_edge();
    end
    chk(out_count_o == 0, "R11 drained", out_count_o, 0);
    drive(0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule